// File: doc/BRIEF.md
# Self-Recovering Token Sequencer with Two-Phase Clock Outputs

The block is an n-state cyclic sequencer held in only n-1 flip-flops. The all-zero vector stands for the home state. Each of the other states is marked by a single set bit, a token, that walks down a shift chain.

The first stage is loaded with the NOR of every state bit. A machine at home therefore always launches a new token on the next enabled clock. A token that leaves the last stage returns the machine to home, because the end of the chain does not wrap around. This structure also repairs upsets without any dedicated recovery logic:
- A vector stuck at zero restarts by itself.
- Surplus ones drain out of the far end of the chain.

With its default of four states, the sequencer drives two non-overlapping clock phases. Each phase is high in a single state, and a gap state lies between them. An injection mask lets a test environment flip arbitrary state bits to model upsets. An illegal flag reports vectors that hold more than one token.

Top module: `onehot_recover_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes all zeros on that edge; `atHome` then reads 1 and `illegal`, `phaseA`, `phaseB` read 0.
- R2: From the all-zero home state, with `enable` high and `injMask` zero, the next clock yields a state with only bit 0 set.
- R3: With `enable` high and `injMask` zero, bit i takes the old bit i-1 for every i from 1 to NUM_STATES-2. The old top bit is dropped and is not fed back.
- R4: With `enable` low and `injMask` zero, the state holds its value across the clock edge.
- R5: A nonzero `injMask` replaces the state with state XOR `injMask` on the next clock, whatever the value of `enable`.
- R6: `illegal` is high, in the same cycle, exactly when two or more state bits are set. `atHome` is high exactly when all state bits are zero.
- R7: `phaseA` is high exactly when the state has only bit 0 set. `phaseB` is high exactly when the state has only the top bit (NUM_STATES-2) set. The two are never high together.
- R8: Starting from any state vector and with `enable` high and `injMask` zero, the state holds at most one set bit after at most NUM_STATES-1 clocks, and it stays that way from then on.
- R9: From home, with `enable` high, the legal sequence visits home, bit 0, bit 1, up to the top bit, and returns to home after exactly NUM_STATES clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, forces home |
| enable | input | 1 | Advance the sequence on this clock |
| injMask | input | NUM_STATES-1 | Nonzero value flips the marked state bits (upset model) |
| stateOut | output | NUM_STATES-1 | Current state vector, bit 0 is the first stage |
| atHome | output | 1 | All state bits are zero |
| illegal | output | 1 | More than one state bit is set |
| phaseA | output | 1 | First clock phase, high in the first token state only |
| phaseB | output | 1 | Second clock phase, high in the last token state only |

## Verification
The following are checked on every cycle:
- the home-to-first-stage launch;
- the shift step that drops the top bit;
- holding while disabled;
- the XOR effect of injection;
- that the phases never overlap;
- that a legal vector stays legal once it advances.

The bounded return to legality from every possible corrupted vector is shown only by the bench, which injects each pattern in turn and counts the clocks to recovery. The full cycle length of the sequence is likewise shown only by the bench. The same holds for the exact match of the `atHome` and `illegal` decodes under mixed random enable and upset traffic.

// File: rtl/onehot_recover_seq_pkg.sv
package onehot_recover_seq_pkg;

  typedef struct packed {
    logic advance;
    logic inject;
  } seqStrobeT;

endpackage

// File: rtl/onehot_recover_seq_ctrl.sv
module onehot_recover_seq_ctrl
  import onehot_recover_seq_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              enable,
  input  logic [STAGES-1:0] injMask,
  output seqStrobeT         strobe
);

  // Injection wins over advance (R5)
  always_comb begin
    strobe.inject  = |injMask;
    strobe.advance = enable & ~strobe.inject;
  end

endmodule

// File: rtl/onehot_recover_seq_datapath.sv
module onehot_recover_seq_datapath
  import onehot_recover_seq_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobeT         strobe,
  input  logic [STAGES-1:0] injMask,
  output logic [STAGES-1:0] stateQ,
  output logic              atHome,
  output logic              illegal,
  output logic              phaseA,
  output logic              phaseB
);

  localparam logic [STAGES-1:0] FIRST_CODE = STAGES'(1);
  localparam logic [STAGES-1:0] LAST_CODE  = STAGES'(1) << (STAGES - 1);
  localparam int                CNT_W      = $clog2(STAGES + 1);

  logic [STAGES-1:0] shifted;
  logic [CNT_W-1:0]  onesCount;

  // First stage: NOR of all bits, rest: plain chain with no wrap
  assign shifted[0] = ~|stateQ;
  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
      assign shifted[i] = stateQ[i-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= '0;
    end else if (strobe.inject) begin
      stateQ <= stateQ ^ injMask;
    end else if (strobe.advance) begin
      stateQ <= shifted;
    end
  end

  always_comb begin
    onesCount = '0;
    for (int i = 0; i < STAGES; i++) begin
      onesCount = onesCount + CNT_W'(stateQ[i]);
    end
  end

  assign atHome  = (stateQ == '0);
  assign illegal = (onesCount > CNT_W'(1));
  assign phaseA  = (stateQ == FIRST_CODE);
  assign phaseB  = (stateQ == LAST_CODE);

endmodule

// File: rtl/onehot_recover_seq.sv
module onehot_recover_seq
  import onehot_recover_seq_pkg::*;
#(
  parameter int NUM_STATES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic [NUM_STATES-2:0] injMask,
  output logic [NUM_STATES-2:0] stateOut,
  output logic                  atHome,
  output logic                  illegal,
  output logic                  phaseA,
  output logic                  phaseB
);

  localparam int STAGES = NUM_STATES - 1;

  seqStrobeT strobe;

  onehot_recover_seq_ctrl #(.STAGES(STAGES)) u_ctrl (
    .enable  (enable),
    .injMask (injMask),
    .strobe  (strobe)
  );

  onehot_recover_seq_datapath #(.STAGES(STAGES)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .injMask (injMask),
    .stateQ  (stateOut),
    .atHome  (atHome),
    .illegal (illegal),
    .phaseA  (phaseA),
    .phaseB  (phaseB)
  );

endmodule

// File: rtl/onehot_recover_seq_chk.sv
module onehot_recover_seq_chk #(
  parameter int NUM_STATES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  enable,
  input logic [NUM_STATES-2:0] injMask,
  input logic [NUM_STATES-2:0] stateOut,
  input logic                  atHome,
  input logic                  illegal,
  input logic                  phaseA,
  input logic                  phaseB
);

  localparam int STAGES = NUM_STATES - 1;

  AST_RESET_HOME: assert property (@(posedge clk)
    rst |=> (stateOut == '0)); // R1

  AST_HOME_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (atHome && enable && injMask == '0) |=> (stateOut == STAGES'(1))); // R2

  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (enable && injMask == '0) |=>
      (stateOut[STAGES-1:1] == $past(stateOut[STAGES-2:0]))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!enable && injMask == '0) |=> $stable(stateOut)); // R4

  AST_UPSET_XOR: assert property (@(posedge clk) disable iff (rst)
    (injMask != '0) |=> (stateOut == $past(stateOut ^ injMask))); // R5

  AST_PHASE_GAP: assert property (@(posedge clk) disable iff (rst)
    !(phaseA && phaseB)); // R7

  AST_LEGAL_CLOSED: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(stateOut) && injMask == '0) |=> !illegal); // R8

endmodule

bind onehot_recover_seq onehot_recover_seq_chk #(.NUM_STATES(NUM_STATES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .injMask  (injMask),
  .stateOut (stateOut),
  .atHome   (atHome),
  .illegal  (illegal),
  .phaseA   (phaseA),
  .phaseB   (phaseB)
);

// File: tb/onehot_recover_seq_test.sv
module onehot_recover_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_STATES = 4;
  localparam int STAGES     = NUM_STATES - 1;
  localparam logic [STAGES-1:0] LAST_CODE = STAGES'(1) << (STAGES - 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic [STAGES-1:0] injMask = '0;
  logic [STAGES-1:0] stateOut;
  logic              atHome, illegal, phaseA, phaseB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [STAGES-1:0] expS = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onehot_recover_seq #(.NUM_STATES(NUM_STATES)) uut (
    .clk(clk), .rst(rst), .enable(enable), .injMask(injMask),
    .stateOut(stateOut), .atHome(atHome), .illegal(illegal),
    .phaseA(phaseA), .phaseB(phaseB)
  );

  function automatic logic [STAGES-1:0] modelNext(logic [STAGES-1:0] s,
                                                  logic en, logic [STAGES-1:0] m);
    if (m != '0) return s ^ m;
    if (en) return {s[STAGES-2:0], ~|s};
    return s;
  endfunction

  function automatic int popCount(logic [STAGES-1:0] s);
    int n = 0;
    for (int i = 0; i < STAGES; i++) n += int'(s[i]);
    return n;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(string req);
    check({req, " state"}, 32'(stateOut), 32'(expS));
    check("R6 atHome", 32'(atHome), 32'(expS == '0));
    check("R6 illegal", 32'(illegal), 32'(popCount(expS) > 1));
    check("R7 phaseA", 32'(phaseA), 32'(expS == STAGES'(1)));
    check("R7 phaseB", 32'(phaseB), 32'(expS == LAST_CODE));
  endtask

  task automatic step(logic en, logic [STAGES-1:0] m);
    @(negedge clk);
    enable  = en;
    injMask = m;
    @(posedge clk);
    #1;
    expS = modelNext(expS, en, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5817));
    repeat (3) @(posedge clk);
    #1;
    expS = '0;
    checkOutputs("R1 reset");
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R9: two full legal cycles
    for (int c = 0; c < 2 * NUM_STATES; c++) begin
      step(1'b1, '0);
      checkOutputs(c == 0 ? "R2 launch" : "R3 shift");
      if ((c + 1) % NUM_STATES == 0)
        check("R9 cycle length", 32'(stateOut), 32'(0));
    end

    // R4 hold in a mid-chain state
    step(1'b1, '0);
    step(1'b1, '0);
    for (int h = 0; h < 3; h++) begin
      step(1'b0, '0);
      checkOutputs("R4 hold");
    end

    // R5 injection overrides enable
    step(1'b1, STAGES'(3'b101));
    checkOutputs("R5 inject");

    // R8 every pattern recovers within NUM_STATES-1 clocks
    for (int p = 0; p < (1 << STAGES); p++) begin
      logic [STAGES-1:0] want = STAGES'(p);
      if (expS != want) begin
        step(1'b0, expS ^ want);
        checkOutputs("R5 inject pattern");
      end
      for (int k = 0; k < STAGES; k++) begin
        step(1'b1, '0);
        checkOutputs("R3 drain");
      end
      check("R8 recovered", 32'(popCount(stateOut) <= 1), 32'(1));
      for (int k = 0; k < NUM_STATES; k++) begin
        step(1'b1, '0);
        check("R8 stays legal", 32'(illegal), 32'(0));
      end
    end

    // Random traffic
    for (int r = 0; r < 400; r++) begin
      logic en = 1'($urandom);
      logic [STAGES-1:0] m = ($urandom % 4 == 0) ? STAGES'($urandom) : '0;
      step(en, m);
      checkOutputs("R3 R5 random");
      check("R7 no overlap", 32'(phaseA & phaseB), 32'(0));
    end

    // R1 reset mid-run from an illegal vector
    step(1'b0, STAGES'(3'b110));
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    expS = '0;
    checkOutputs("R1 reset mid-run");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule